// File: doc/BRIEF.md
# Edge-Aligned PWM Timer with Buffered Duty Update

This block is an up-counting PWM generator for a timer subsystem. A counter advances on a count-clock enable strobe. One compare register defines the period and a second defines the duty edge. When the counter equals the period value it returns to zero, the output goes to its active level and an interrupt pulse is raised. When the counter equals the duty value the output goes to its inactive level and the counter keeps counting.

Software may rewrite the duty value while the timer is running. That value is not sent to the comparator straight away. It waits in a holding register until the counter next matches the duty value that is still in use, so a PWM period never sees a half-applied edge. The write must also come early enough: the commit needs a minimum number of count clocks between the write and the match. A write that comes too late waits for a later cycle.

A polarity input selects whether the active level is high or low. Dropping the run bit stops the timer at once and parks the output.

Top module: `duty_pwm_timer`

## Requirements
- R1: After synchronous reset, with `pol_inv`=0, `pwm_out` is 0 and `irq_pulse` is 0. The counter, the compare registers and the pending-write state are all cleared.
- R2: The first `cnt_tick` after `run_en` goes to 1 is swallowed and the counter stays at 00h. On each later tick the counter is compared and then advances. The output stays inactive until the first period match.
- R3: On a tick where the counter equals the period value, the counter goes to 00h and the output goes active. `irq_pulse` goes high and stays high until the next counting tick, which is one count clock.
- R4: On a tick where the counter equals the duty value, the output goes inactive, the counter advances by one and no interrupt is raised. When the period and duty values are equal, the period match takes priority. With duty value D, the output is therefore active for D+1 count clocks.
- R5: A duty write while `run_en`=1 goes to a holding register. The duty edge keeps using the previous value until the commit.
- R6: A held value is committed on a tick that matches the previous duty value, but only if that tick is at least the third counting tick after the write. The output still goes inactive on that match.
- R7: A held value that misses the three-tick window stays pending and is committed at a later qualifying match. A newer write replaces the held value and restarts the window.
- R8: Setting `run_en` to 0 forces the output inactive, drives `irq_pulse` to 0 and sets the counter to 00h. Any held duty value becomes the active one. When `run_en` is set again, the first tick is swallowed again.
- R9: While stopped, a duty write takes effect at once. A period write takes effect at once in both the stopped and the running state.
- R10: `pol_inv`=1 inverts `pwm_out`, so the inactive level is 1 and the active level is 0.
- R11: With period A5h and duty 02h, a write of 03h late in a PWM period lets the next period still end its active phase at the 02h match. The period after that ends its active phase at 03h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-clock enable strobe, one system clock wide |
| run_en | input | 1 | Timer run bit |
| period_we | input | 1 | Period compare write strobe |
| period_wdata | input | 8 | Period compare write value |
| duty_we | input | 1 | Duty compare write strobe |
| duty_wdata | input | 8 | Duty compare write value |
| pol_inv | input | 1 | Output polarity select |
| pwm_out | output | 1 | PWM output |
| irq_pulse | output | 1 | Period interrupt, one count clock wide |

## Verification
The hardest state to reach is a duty write that lands too close to the match of the old value. The pending value must then survive that match, still produce the old inactive edge, and be committed one PWM period later. The stimulus tracks the counter in its own model and issues the write in the exact gap before the matching tick. It also issues a second write two ticks after a first one, and drops the run bit while a write is still held. A long A5h-period run with a late 02h-to-03h write covers the deferral across a full PWM period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    // Width of the saturating tick counter for the settle window.
    localparam int unsigned PWMT_WIN_W = 4;

    // Run phase: waiting for the swallowed tick, or counting.
    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_COUNT = 1'b1
    } pwmt_phase_t;

    // Per-cycle events produced by the counter stage.
    typedef struct packed {
        logic swallow;     // tick absorbed right after enabling
        logic adv;         // counting tick
        logic period_hit;  // counting tick with counter == period
        logic duty_hit;    // counting tick with counter == duty, no period hit
    } pwmt_evt_t;

    function automatic logic [PWMT_WIN_W-1:0] pwmt_win_step(
        input logic [PWMT_WIN_W-1:0] w
    );
        return (&w) ? w : w + 1'b1;
    endfunction

    // True when the current tick is at least the need-th counting tick.
    function automatic logic pwmt_window_met(
        input logic [PWMT_WIN_W-1:0] w,
        input int unsigned           need
    );
        int unsigned seen;
        seen = 32'(w) + 32'd1;
        return seen >= need;
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic [CNT_W-1:0] cnt,
    output pwmt_evt_t        evt
);

    pwmt_phase_t phase;

    always_comb begin
        evt.swallow    = run_en && tick && (phase == PH_WAIT);
        evt.adv        = run_en && tick && (phase == PH_COUNT);
        evt.period_hit = evt.adv && (cnt == period);
        evt.duty_hit   = evt.adv && !evt.period_hit && (cnt == duty);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            phase <= PH_WAIT;
            cnt   <= '0;
        end else if (evt.swallow) begin
            phase <= PH_COUNT;
        end else if (evt.adv) begin
            cnt <= evt.period_hit ? '0 : cnt + 1'b1;
        end
    end

    // R2: the swallowed tick leaves the counter at zero
    a_r2_swallow_keeps_zero: assert property (@(posedge clk) disable iff (rst)
        evt.swallow |=> (cnt == '0));

    // R3: a period match clears the counter
    a_r3_period_clears: assert property (@(posedge clk) disable iff (rst)
        (evt.period_hit && run_en) |=> (cnt == '0));

    // R4: a duty match does not clear the counter
    a_r4_duty_keeps_counting: assert property (@(posedge clk) disable iff (rst)
        evt.duty_hit |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/pwmt_cmp_bank.sv
module pwmt_cmp_bank
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             adv,
    input  logic             duty_hit,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] duty_act
);

    logic [CNT_W-1:0]      duty_hold;
    logic                  hold_valid;
    logic [PWMT_WIN_W-1:0] win;
    logic                  commit;

    assign commit = duty_hit && hold_valid && !duty_we
                    && pwmt_window_met(win, SETTLE_TICKS);

    // Period register: always written directly.
    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
        end else if (period_we) begin
            period <= period_wdata;
        end
    end

    // Duty register with a holding stage while running.
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_act   <= '0;
            duty_hold  <= '0;
            hold_valid <= 1'b0;
            win        <= '0;
        end else if (!run_en) begin
            win <= '0;
            if (duty_we) begin
                duty_act   <= duty_wdata;
                hold_valid <= 1'b0;
            end else if (hold_valid) begin
                duty_act   <= duty_hold;
                hold_valid <= 1'b0;
            end
        end else if (duty_we) begin
            duty_hold  <= duty_wdata;
            hold_valid <= 1'b1;
            win        <= '0;
        end else if (hold_valid && adv) begin
            win <= pwmt_win_step(win);
            if (commit) begin
                duty_act   <= duty_hold;
                hold_valid <= 1'b0;
            end
        end
    end

    // R5: a running write never reaches the comparator in the same step
    a_r5_write_is_held: assert property (@(posedge clk) disable iff (rst)
        (run_en && duty_we) |=> $stable(duty_act));

    // R6: while running, the active duty changes only on a duty match
    a_r6_commit_on_match_only: assert property (@(posedge clk) disable iff (rst)
        (run_en && !duty_hit) |=> $stable(duty_act));

    // R9: a stopped write lands at once
    a_r9_stopped_write_direct: assert property (@(posedge clk) disable iff (rst)
        (!run_en && duty_we) |=> (duty_act == $past(duty_wdata)));

    // R9: period writes are never buffered
    a_r9_period_direct: assert property (@(posedge clk) disable iff (rst)
        period_we |=> (period == $past(period_wdata)));

endmodule

// File: rtl/pwmt_level.sv
module pwmt_level (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic adv,
    input  logic period_hit,
    input  logic duty_hit,
    input  logic pol_inv,
    output logic pwm_out,
    output logic irq
);

    logic active;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            active <= 1'b0;
            irq    <= 1'b0;
        end else if (adv) begin
            if (period_hit) begin
                active <= 1'b1;
                irq    <= 1'b1;
            end else begin
                irq <= 1'b0;
                if (duty_hit) begin
                    active <= 1'b0;
                end
            end
        end
    end

    assign pwm_out = active ^ pol_inv;

    // R8: stopping parks the output and the interrupt
    a_r8_stop_parks: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!active && !irq));

    // R3: the interrupt lasts one count clock
    a_r3_irq_one_tick: assert property (@(posedge clk) disable iff (rst)
        (irq && adv && !period_hit) |=> !irq);

    // R4: a duty match ends the active phase without an interrupt
    a_r4_duty_inactive: assert property (@(posedge clk) disable iff (rst)
        (duty_hit && run_en) |=> (!active && !irq));

endmodule

// File: rtl/duty_pwm_timer.sv
module duty_pwm_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W        = 8,
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_tick,
    input  logic             run_en,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             pol_inv,
    output logic             pwm_out,
    output logic             irq_pulse
);

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] cnt;
    pwmt_evt_t        evt;

    pwmt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .tick   (cnt_tick),
        .period (period),
        .duty   (duty_act),
        .cnt    (cnt),
        .evt    (evt)
    );

    pwmt_cmp_bank #(.CNT_W(CNT_W), .SETTLE_TICKS(SETTLE_TICKS)) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .adv          (evt.adv),
        .duty_hit     (evt.duty_hit),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .duty_we      (duty_we),
        .duty_wdata   (duty_wdata),
        .period       (period),
        .duty_act     (duty_act)
    );

    pwmt_level u_level (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .adv        (evt.adv),
        .period_hit (evt.period_hit),
        .duty_hit   (evt.duty_hit),
        .pol_inv    (pol_inv),
        .pwm_out    (pwm_out),
        .irq        (irq_pulse)
    );

    // R2: a swallowed tick never raises the interrupt
    a_r2_no_irq_on_swallow: assert property (@(posedge clk) disable iff (rst)
        (evt.swallow && !irq_pulse) |=> !irq_pulse);

    // R3: a period match raises the interrupt with the counter at zero
    a_r3_match_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (evt.period_hit && run_en) |=> (irq_pulse && cnt == '0));

    // R1: reset clears the counter and the interrupt
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !irq_pulse));

endmodule

// File: tb/tb_duty_pwm_timer.sv
module tb_duty_pwm_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_tick = 1'b0;
    logic       run_en = 1'b0;
    logic       period_we = 1'b0;
    logic [7:0] period_wdata = 8'h00;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = 8'h00;
    logic       pol_inv = 1'b0;
    logic       pwm_out;
    logic       irq_pulse;

    always #4 clk = ~clk;   // 125 MHz

    duty_pwm_timer dut (
        .clk          (clk),
        .rst          (rst),
        .cnt_tick     (cnt_tick),
        .run_en       (run_en),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .duty_we      (duty_we),
        .duty_wdata   (duty_wdata),
        .pol_inv      (pol_inv),
        .pwm_out      (pwm_out),
        .irq_pulse    (irq_pulse)
    );

    typedef struct {
        logic  pwm;
        logic  irq;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    string scen = "R1";

    // Reference model state, written from the requirements.
    bit         m_started = 0;
    logic [7:0] m_cnt = 0, m_per = 0, m_duty = 0, m_hold = 0;
    bit         m_hv = 0, m_act = 0, m_irq = 0;
    int         m_win = 0;
    bit         g_run = 0, g_pol = 0;

    // Monitor: compares each expected item after the edge it belongs to.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (pwm_out !== e.pwm || irq_pulse !== e.irq) begin
                n_errors++;
                $display("FAIL %s: pwm_out=%b irq_pulse=%b expected pwm_out=%b irq_pulse=%b",
                         e.tag, pwm_out, irq_pulse, e.pwm, e.irq);
            end
        end
    end

    // Driver: applies one system cycle and pushes the expected outputs.
    task automatic step(input bit tk, input bit pwe, input logic [7:0] pd,
                        input bit dwe, input logic [7:0] dd);
        exp_t  e;
        string t;
        bit    pm, dm, commit;
        @(negedge clk);
        cnt_tick = tk; run_en = g_run; pol_inv = g_pol;
        period_we = pwe; period_wdata = pd; duty_we = dwe; duty_wdata = dd;
        t = "R1";
        if (!g_run) begin
            m_started = 0; m_cnt = 0; m_act = 0; m_irq = 0; m_win = 0;
            t = "R8";
            if (dwe) begin m_duty = dd; m_hv = 0; t = "R9"; end
            else if (m_hv) begin m_duty = m_hold; m_hv = 0; end
            if (pwe) m_per = pd;
        end else begin
            if (tk && !m_started) begin
                m_started = 1; t = "R2";
            end else if (tk) begin
                pm = (m_cnt == m_per);
                dm = !pm && (m_cnt == m_duty);
                commit = dm && m_hv && (m_win + 1 >= 3) && !dwe;
                if (pm) begin
                    m_cnt = 0; m_act = 1; m_irq = 1; t = "R3";
                end else begin
                    m_cnt = m_cnt + 8'd1; m_irq = 0;
                    if (dm) begin m_act = 0; t = commit ? "R6" : "R4"; end
                end
                if (!dwe && m_hv) begin
                    if (commit) begin m_duty = m_hold; m_hv = 0; end
                    if (m_win < 15) m_win++;
                end
            end
            if (pwe) m_per = pd;
            if (dwe) begin m_hold = dd; m_hv = 1; m_win = 0; t = "R5"; end
        end
        e.pwm = m_act ^ g_pol;
        e.irq = m_irq;
        e.tag = {scen, "/", t};
        sb_q.push_back(e);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 8'h00, 0, 8'h00);
            step(0, 0, 8'h00, 0, 8'h00);
        end
    endtask

    task automatic tick_until_cnt(input logic [7:0] c);
        int guard = 0;
        while (m_cnt != c && guard < 600) begin
            ticks(1);
            guard++;
        end
    endtask

    task automatic write_duty(input logic [7:0] d);
        step(0, 0, 8'h00, 1, d);
    endtask

    task automatic write_period(input logic [7:0] p);
        step(0, 1, p, 0, 8'h00);
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        n_checks++;
        if (pwm_out !== 1'b0 || irq_pulse !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: pwm_out=%b irq_pulse=%b expected 0 0", pwm_out, irq_pulse);
        end
        rst = 1'b0;
        step(0, 0, 8'h00, 0, 8'h00);

        // R9: stopped writes are immediate
        scen = "R9";
        write_period(8'h10);
        write_duty(8'h05);

        // R2/R3/R4: start and run several periods
        scen = "R2";
        g_run = 1;
        step(0, 0, 8'h00, 0, 8'h00);
        ticks(60);

        // R5/R6: running write well before the old match
        scen = "R5";
        tick_until_cnt(8'h08);
        write_duty(8'h09);
        ticks(45);

        // R7: write just before the matching tick, too late
        scen = "R7";
        tick_until_cnt(8'h09);
        write_duty(8'h03);
        ticks(40);
        // R7: newer write overwrites the held one and restarts the window
        tick_until_cnt(8'h01);
        write_duty(8'h07);
        ticks(1);
        write_duty(8'h0B);
        ticks(50);

        // R9: period write while running
        scen = "R9";
        tick_until_cnt(8'h04);
        write_period(8'h0C);
        ticks(40);

        // R10: inverted polarity
        scen = "R10";
        g_pol = 1;
        ticks(30);
        g_pol = 0;

        // R8: stop with a held value, then restart
        scen = "R8";
        tick_until_cnt(8'h02);
        write_duty(8'h04);
        g_run = 0;
        step(0, 0, 8'h00, 0, 8'h00);
        step(1, 0, 8'h00, 0, 8'h00);
        g_run = 1;
        ticks(30);

        // R4: period and duty equal, period wins
        scen = "R4";
        g_run = 0;
        step(0, 0, 8'h00, 0, 8'h00);
        write_period(8'h06);
        write_duty(8'h06);
        g_run = 1;
        ticks(25);

        // R11: A5h period, duty 02h then 03h
        scen = "R11";
        g_run = 0;
        step(0, 0, 8'h00, 0, 8'h00);
        write_period(8'hA5);
        write_duty(8'h02);
        g_run = 1;
        ticks(170);
        tick_until_cnt(8'h80);
        write_duty(8'h03);
        ticks(400);

        // R8: final stop
        scen = "R8";
        g_run = 0;
        step(0, 0, 8'h00, 0, 8'h00);
        step(1, 0, 8'h00, 0, 8'h00);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule